// File: doc/BRIEF.md
# Signed Phase Calibration Delay

This block lines up two sample streams in time so that a small phase error in a sensing transducer can be cancelled digitally. Both streams are taken in on a slow sample tick that an internal divider derives from the fast clock, one tick every `TICK_DIV` clocks. The first stream always passes through a fixed delay of `NOM` ticks. The second stream passes through `NOM` ticks plus a signed calibration value, so it can be retarded or advanced relative to the first by whole ticks.

The calibration value is an 8-bit two's complement byte written through a one-cycle write strobe. Its usable range is asymmetric, from −98 to +92. Any write outside that range is clamped to the nearer end before it is used. The default fixed delay equals the magnitude of the most negative setting. At −98 the second stream therefore leaves with no net delay, and at +92 it leaves 190 ticks late. Each step is four clocks, which is roughly 1.12 µs at a 3.58 MHz clock, or about 0.024° of a 60 Hz line.

A single valid strobe marks the clock cycle in which both aligned outputs carry new data. Changing the calibration byte moves only the read tap of the second stream. The strobe keeps its rhythm, and the first stream is not touched.

Top module: `phcal_delay`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_valid` is 0 and both outputs are 0. After reset the calibration value is 0, which gives stream 2 a delay of 98 ticks.
- R2: A tick occurs every 4 clocks. The inputs are sampled on the clock edge of each tick, and `out_valid` is high for exactly the one cycle that follows that edge. Consecutive pulses are exactly 4 cycles apart.
- R3: In the cycle where `out_valid` is high after tick k, `ch1_out` equals the `ch1_in` sampled at tick k−98, or 0 if fewer than 98 ticks have passed since reset.
- R4: `cal_wdata` is read as 8-bit two's complement. After tick k, `ch2_out` equals the `ch2_in` sampled at tick k−(98+cal), or 0 if that tick came before reset. For example, 8'h00 gives 98 and 8'h01 gives 99.
- R5: A negative calibration value shortens the stream 2 delay. 8'hFC (−4) gives 94 ticks, 8'hF0 gives 82 ticks, and 8'h9E (−98) gives 0 ticks, in which case the sample taken at tick k appears after tick k.
- R6: 8'h5C (+92) gives the largest delay, 190 ticks.
- R7: Writes below −98 (for example 8'h80 or 8'h9D) act as −98, which gives 0 ticks.
- R8: Writes above +92 (for example 8'h7F or 8'h5D) act as +92, which gives 190 ticks.
- R9: A write on `cal_we` is captured at the next clock edge. It governs the first tick edge strictly after that edge. Both outputs hold their value in every cycle where `out_valid` is low, and a write does not disturb the pulse spacing.
- R10: The calibration value never changes the delay of stream 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch1_in | input | 20 | Stream 1 sample, signed |
| ch2_in | input | 20 | Stream 2 sample, signed |
| cal_we | input | 1 | Calibration write strobe |
| cal_wdata | input | 8 | Calibration byte, two's complement |
| ch1_out | output | 20 | Stream 1 delayed by the fixed amount |
| ch2_out | output | 20 | Stream 2 delayed by fixed amount plus calibration |
| out_valid | output | 1 | One-cycle strobe marking new output data |

## Verification
The two streams are driven with different sequences that change on every clock, not only on every tick. A swapped stream, an off-by-one in the delay, or a sample taken on the wrong clock of the tick period therefore each produce a visible mismatch. The calibration values walk through zero, small positive and negative offsets, both legal extremes, and values just past each extreme and at the extremes of the byte. This separates correct clamping from wrap-around and from sign errors. A reset in the middle of a run shows that the default delay comes back and that stale samples do not leak out.

// File: rtl/phcal_pkg.sv
package phcal_pkg;

   // Saturate an integer into [lo, hi].
   function automatic int clamp_int(input int v, input int lo, input int hi);
      if (v < lo)
         return lo;
      else if (v > hi)
         return hi;
      else
         return v;
   endfunction

endpackage

// File: rtl/phcal_tick.sv
module phcal_tick #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV <= 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_div
         localparam int CW = $clog2(DIV);
         logic [CW-1:0] cnt;
         assign tick = (cnt == CW'(DIV - 1));
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt <= '0;
            else if (tick)
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/phcal_cal_reg.sv
module phcal_cal_reg #(
   parameter int CAL_W   = 8,
   parameter int CAL_MIN = -98,
   parameter int CAL_MAX = 92
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [CAL_W-1:0]        wdata,
   output logic signed [CAL_W-1:0] q
);
   int                     wr_val;
   logic signed [CAL_W-1:0] sat_val;

   always_comb begin
      wr_val  = int'($signed(wdata));
      sat_val = CAL_W'(phcal_pkg::clamp_int(wr_val, CAL_MIN, CAL_MAX));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (we)
         q <= sat_val;
   end
endmodule

// File: rtl/phcal_delay_line.sv
module phcal_delay_line #(
   parameter int W     = 20,
   parameter int MAX_D = 190,
   parameter int D_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic signed [W-1:0] din,
   input  logic [D_W-1:0]      delay,
   output logic signed [W-1:0] dout
);
   generate
      if (MAX_D == 0) begin : g_thru
         always_ff @(posedge clk) begin
            if (!rst_n)
               dout <= '0;
            else if (tick)
               dout <= din;
         end
      end else begin : g_ring
         localparam int N     = MAX_D + 1;
         localparam int PTR_W = $clog2(N);

         logic signed [W-1:0] mem [N];
         logic [PTR_W-1:0]    wp;
         logic [PTR_W-1:0]    rp;
         logic [PTR_W:0]      d_ext;
         logic [PTR_W:0]      rd_ext;
         logic [D_W-1:0]      eff;
         logic                unused_top;

         always_comb begin
            eff   = (int'(delay) > MAX_D) ? D_W'(MAX_D) : delay;
            d_ext = (PTR_W+1)'(eff);
            if ({1'b0, wp} >= d_ext)
               rd_ext = {1'b0, wp} - d_ext;
            else
               rd_ext = {1'b0, wp} + (PTR_W+1)'(N) - d_ext;
            rp         = rd_ext[PTR_W-1:0];
            unused_top = rd_ext[PTR_W];
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               wp   <= '0;
               dout <= '0;
               for (int i = 0; i < N; i++)
                  mem[i] <= '0;
            end else if (tick) begin
               mem[wp] <= din;
               wp      <= (wp == PTR_W'(N - 1)) ? '0 : wp + 1'b1;
               dout    <= (d_ext == '0) ? din : mem[rp];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/phcal_delay.sv
module phcal_delay #(
   parameter int DATA_W   = 20,
   parameter int CAL_W    = 8,
   parameter int CAL_MIN  = -98,
   parameter int CAL_MAX  = 92,
   parameter int TICK_DIV = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [DATA_W-1:0] ch1_in,
   input  logic signed [DATA_W-1:0] ch2_in,
   input  logic                     cal_we,
   input  logic [CAL_W-1:0]         cal_wdata,
   output logic signed [DATA_W-1:0] ch1_out,
   output logic signed [DATA_W-1:0] ch2_out,
   output logic                     out_valid
);
   localparam int NOM    = -CAL_MIN;
   localparam int MAX_D2 = NOM + CAL_MAX;
   localparam int D1_W   = (NOM > 0) ? $clog2(NOM + 1) : 1;
   localparam int D2_W   = $clog2(MAX_D2 + 1);

   generate
      if (CAL_MIN >= 0 || CAL_MAX <= 0) begin : g_bad_span
         $error("calibration span must straddle zero");
      end
      if (CAL_MIN < -(2 ** (CAL_W - 1)) || CAL_MAX > 2 ** (CAL_W - 1) - 1) begin : g_bad_width
         $error("calibration span does not fit CAL_W");
      end
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
   endgenerate

   logic                    tick;
   logic signed [CAL_W-1:0] cal_q;
   int                      ch2_sum;
   logic [D2_W-1:0]         ch2_delay;

   phcal_tick #(.DIV(TICK_DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   phcal_cal_reg #(
      .CAL_W  (CAL_W),
      .CAL_MIN(CAL_MIN),
      .CAL_MAX(CAL_MAX)
   ) u_cal (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (cal_we),
      .wdata(cal_wdata),
      .q    (cal_q)
   );

   always_comb begin
      ch2_sum   = NOM + int'(cal_q);
      ch2_delay = D2_W'(ch2_sum);
   end

   phcal_delay_line #(
      .W    (DATA_W),
      .MAX_D(NOM),
      .D_W  (D1_W)
   ) u_line1 (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .din  (ch1_in),
      .delay(D1_W'(NOM)),
      .dout (ch1_out)
   );

   phcal_delay_line #(
      .W    (DATA_W),
      .MAX_D(MAX_D2),
      .D_W  (D2_W)
   ) u_line2 (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .din  (ch2_in),
      .delay(ch2_delay),
      .dout (ch2_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         out_valid <= 1'b0;
      else
         out_valid <= tick;
   end
endmodule

// File: rtl/phcal_delay_chk.sv
module phcal_delay_chk #(
   parameter int DATA_W   = 20,
   parameter int CAL_W    = 8,
   parameter int CAL_MIN  = -98,
   parameter int CAL_MAX  = 92,
   parameter int TICK_DIV = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     out_valid,
   input logic signed [DATA_W-1:0] ch1_out,
   input logic signed [DATA_W-1:0] ch2_out,
   input logic signed [DATA_W-1:0] ch2_in,
   input logic signed [CAL_W-1:0]  cal_q
);
   int   gap;
   logic seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap  <= 0;
         seen <= 1'b0;
      end else if (out_valid) begin
         gap  <= 0;
         seen <= 1'b1;
      end else begin
         gap <= gap + 1;
      end
   end

   // R2
   valid_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && seen) |-> (gap == TICK_DIV - 1));

   generate
      if (TICK_DIV > 1) begin : g_pulse
         // R2
         valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |=> !out_valid);
      end
   endgenerate

   // R9
   hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(ch1_out) && $stable(ch2_out)));

   // R7 R8
   cal_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cal_q) >= CAL_MIN) && (int'(cal_q) <= CAL_MAX));

   // R5
   zero_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && int'($past(cal_q)) == CAL_MIN) |-> (ch2_out == $past(ch2_in)));
endmodule

bind phcal_delay phcal_delay_chk #(
   .DATA_W  (DATA_W),
   .CAL_W   (CAL_W),
   .CAL_MIN (CAL_MIN),
   .CAL_MAX (CAL_MAX),
   .TICK_DIV(TICK_DIV)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .out_valid(out_valid),
   .ch1_out  (ch1_out),
   .ch2_out  (ch2_out),
   .ch2_in   (ch2_in),
   .cal_q    (cal_q)
);

// File: tb/test_phcal_delay.sv
module test_phcal_delay;
   localparam int W      = 20;
   localparam int NOM    = 98;
   localparam int NVEC   = 10;
   localparam int RUN_TK = 200;

   localparam logic [7:0] VEC_CAL [NVEC] = '{8'h00, 8'hFC, 8'h9E, 8'h5C, 8'h01,
                                             8'h80, 8'h9D, 8'h7F, 8'h5D, 8'hF0};
   localparam int         VEC_EXP [NVEC] = '{98, 94, 0, 190, 99, 0, 0, 190, 190, 82};
   localparam string      VEC_TAG [NVEC] = '{"R4", "R5", "R5", "R6", "R4",
                                             "R7", "R7", "R8", "R8", "R5"};

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic signed [W-1:0] ch1_in = '0;
   logic signed [W-1:0] ch2_in = '0;
   logic                cal_we = 1'b0;
   logic [7:0]          cal_wdata = '0;
   logic signed [W-1:0] ch1_out;
   logic signed [W-1:0] ch2_out;
   logic                out_valid;

   phcal_delay i_phcal_delay (
      .clk      (clk),
      .rst_n    (rst_n),
      .ch1_in   (ch1_in),
      .ch2_in   (ch2_in),
      .cal_we   (cal_we),
      .cal_wdata(cal_wdata),
      .ch1_out  (ch1_out),
      .ch2_out  (ch2_out),
      .out_valid(out_valid)
   );

   always #10 clk = ~clk;

   int total = 0;
   int bad   = 0;

   logic signed [W-1:0] hist1 [4096];
   logic signed [W-1:0] hist2 [4096];
   int    v = 0;
   int    gap = 0;
   int    cyc = 0;
   int    d_cur = NOM;
   int    d_new = NOM;
   string tag_cur = "R1";
   string tag_new = "R1";
   bit    upd = 0;
   bit    req = 0;
   logic [7:0] req_val = '0;
   int    req_exp = 0;
   string req_tag = "";
   bit    req_rst = 0;
   bit    req_rel = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      logic signed [W-1:0] e1;
      logic signed [W-1:0] e2;
      if (rst_n && out_valid) begin
         hist1[v] = ch1_in;
         hist2[v] = ch2_in;
         e1 = (v >= NOM) ? hist1[v - NOM] : '0;
         e2 = (v >= d_cur) ? hist2[v - d_cur] : '0;
         chk(ch1_out == e1, "R3 R10 ch1", ch1_out, e1);
         chk(ch2_out == e2, {tag_cur, " R9 ch2"}, ch2_out, e2);
         if (v > 0)
            chk(gap == 3, "R2 R9 gap", gap, 3);
         v++;
         gap = 0;
      end else if (rst_n) begin
         gap++;
      end
      if (upd) begin
         d_cur   = d_new;
         tag_cur = tag_new;
         upd     = 0;
      end
      cal_we = 1'b0;
      if (req) begin
         cal_we    = 1'b1;
         cal_wdata = req_val;
         d_new     = req_exp;
         tag_new   = req_tag;
         upd       = 1;
         req       = 0;
      end
      if (req_rst) begin
         rst_n   = 1'b0;
         v       = 0;
         gap     = 0;
         d_cur   = NOM;
         tag_cur = "R1";
         req_rst = 0;
      end
      if (req_rel) begin
         rst_n   = 1'b1;
         req_rel = 0;
      end
      ch1_in = W'(cyc * 37 + 11);
      ch2_in = W'((cyc * cyc * 13) ^ 'h8A5C3);
      cyc++;
   endtask

   initial begin
      forever begin
         @(negedge clk);
         step();
      end
   end

   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++)
         @(negedge clk);
   endtask

   task automatic wait_ticks(input int n);
      int target;
      target = v + n;
      while (v < target)
         @(negedge clk);
   endtask

   initial begin
      wait_cycles(5);
      // R1: state while reset is held
      chk(out_valid == 1'b0, "R1 valid", out_valid, 0);
      chk(ch1_out == '0, "R1 ch1", ch1_out, 0);
      chk(ch2_out == '0, "R1 ch2", ch2_out, 0);
      req_rel = 1;
      wait_cycles(2);
      // R1: first cycle after release
      chk(out_valid == 1'b0, "R1 valid after release", out_valid, 0);
      wait_ticks(RUN_TK);
      for (int i = 0; i < NVEC; i++) begin
         req_val = VEC_CAL[i];
         req_exp = VEC_EXP[i];
         req_tag = VEC_TAG[i];
         req     = 1;
         wait_cycles(2);
         wait_ticks(RUN_TK);
      end
      // R1: reset in the middle of a run restores the default delay
      req_rst = 1;
      wait_cycles(4);
      chk(out_valid == 1'b0, "R1 valid mid reset", out_valid, 0);
      chk(ch1_out == '0, "R1 ch1 mid reset", ch1_out, 0);
      chk(ch2_out == '0, "R1 ch2 mid reset", ch2_out, 0);
      req_rel = 1;
      wait_cycles(2);
      wait_ticks(RUN_TK);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 200000);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", v, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule